// File: doc/BRIEF.md
# Banked Memory Mapper Register Unit

This block is the CPU-facing control part of a cartridge memory mapper. The CPU writes to a small set of decoded addresses in the upper half of its address space. Those writes set up bank numbers and a few control bits. From that stored state, the block translates CPU and picture-processor addresses into upper ROM address bits. It also drives the nametable mirroring line and the strobes for a work-RAM device.

Bank numbers are not written directly. The CPU first writes a control byte that holds a 3-bit index and two layout flags. A later write to the data port then loads the bank register that the index selects. One flag exchanges the roles of the first and third 8 KB program windows. The other flag exchanges the two 4 KB halves of the character pattern space. All address translation is purely combinational from the stored state and the present address lines.

The register clock is the CPU bus-phase clock. Writes are captured on its falling edge.

Top module: `mmc_bank_mapper`

## Requirements
- R1: A register write happens only at a falling edge of `bus_clk` where `cpu_rw`=0, `prg_ce_n`=0 and `cpu_a15_13[2]`=1. Any access that fails one of these conditions leaves every output unchanged.
- R2: The write decode key is {A14, A13, A0}.
  - Key 000 is the control byte: bit 7 is the character invert flag, bit 6 is the program swap flag, and bits 2:0 are the bank index.
  - Key 001 is the data port. It loads the bank register selected by the current index.
- R3: Bank registers 0 and 1 map 2 KB character regions at 0000h and 0800h. In these regions `chr_bank` is the stored value with bit 0 replaced by PPU A10.
- R4: Bank registers 2, 3, 4 and 5 map 1 KB character regions at 1000h, 1400h, 1800h and 1C00h.
- R5: The program bank output is selected by the 8 KB window {A14, A13}. A15 is not used for this selection.
  - Window 1 gives bank register 7.
  - Window 3 gives the last bank (all ones).
  - Bank register 6 goes to window 0 when the swap flag is 0, and to window 2 when it is 1.
- R6: The second-to-last bank (all ones minus one) occupies window 2 when the swap flag is 0, and window 0 when it is 1.
- R7: When the invert flag is 1, PPU A12 is inverted before the character lookup.
- R8: The mirroring bit is bit 0 of key 010.
  - When it is 0, `ntab_a10` follows PPU A10.
  - When it is 1, `ntab_a10` follows PPU A11.
- R9: Key 011 carries the work-RAM flags: bit 7 is the enable and bit 6 is the write protect.
  - `wram_ce` is 1 only when the RAM is enabled and `cpu_a15_13` = 011.
  - `wram_we` is 1 only when `wram_ce` is 1, protect is 0 and `cpu_rw` = 0.
- R10: After reset all stored state is zero. In particular, the work RAM is disabled and the index is 0.
- R11: Writes with keys 100 to 111 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | CPU bus-phase clock; writes are taken on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_a15_13 | input | 3 | CPU address bits A15, A14, A13 |
| cpu_a0 | input | 1 | CPU address bit A0 |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| prg_ce_n | input | 1 | Program space select, active low |
| cpu_din | input | 8 | CPU write data |
| ppu_a12_10 | input | 3 | PPU address bits A12, A11, A10 |
| prg_bank | output | PRG_W | Program ROM bank number for the addressed 8 KB window |
| chr_bank | output | CHR_W | Character ROM 1 KB bank number |
| ntab_a10 | output | 1 | Nametable RAM A10 |
| wram_ce | output | 1 | Work-RAM chip enable, active high |
| wram_we | output | 1 | Work-RAM write enable, active high |

## Verification
Random writes cover every decode key, with occasional invalid bus cycles and writes below 8000h. Each batch of writes is followed by probes over all eight CPU windows and all eight PPU regions.

Directed sequences do three jobs:
- Odd stored values for the 2 KB registers show that PPU A10 replaces bit 0.
- Distinct values in all six character registers show whether the invert flag moves the whole lookup or only part of it.
- Toggling the swap flag with distinct bank values confirms that the fixed second-to-last bank and register 6 exchange places while windows 1 and 3 stay put.

The work-RAM flags are tried in all four combinations against both read and write cycles.

// File: rtl/mmc_map_pkg.sv
package mmc_map_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_BANKS = 8;
  localparam int IDX_W     = $clog2(NUM_BANKS);

  typedef struct packed {
    logic             chr_inv;
    logic             prg_swap;
    logic [IDX_W-1:0] idx;
  } ctrl_t;

  typedef enum logic [2:0] {
    KEY_CTRL   = 3'b000,
    KEY_DATA   = 3'b001,
    KEY_MIRROR = 3'b010,
    KEY_WRAM   = 3'b011
  } wkey_e;

  typedef logic [NUM_BANKS-1:0][REG_W-1:0] bank_arr_t;
endpackage

// File: rtl/mmc_reg_file.sv
module mmc_reg_file
  import mmc_map_pkg::*;
(
  input  logic             bus_clk,
  input  logic             rst_sync_n,
  input  logic             wr_strobe,
  input  logic [2:0]       wr_key,
  input  logic [REG_W-1:0] wr_data,
  output ctrl_t            ctrl_q,
  output bank_arr_t        bank_q,
  output logic             mirror_q,
  output logic             wram_en_q,
  output logic             wram_wp_q
);
  logic  ctrl_en, data_en, mirror_en, wram_en_en;
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_en    = wr_strobe && (wr_key == KEY_CTRL);
    data_en    = wr_strobe && (wr_key == KEY_DATA);
    mirror_en  = wr_strobe && (wr_key == KEY_MIRROR);
    wram_en_en = wr_strobe && (wr_key == KEY_WRAM);
    ctrl_d.chr_inv  = wr_data[7];
    ctrl_d.prg_swap = wr_data[6];
    ctrl_d.idx      = wr_data[IDX_W-1:0];
  end

  always_ff @(negedge bus_clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q    <= '0;
      mirror_q  <= 1'b0;
      wram_en_q <= 1'b0;
      wram_wp_q <= 1'b0;
    end else begin
      if (ctrl_en)    ctrl_q   <= ctrl_d;
      if (mirror_en)  mirror_q <= wr_data[0];
      if (wram_en_en) begin
        wram_en_q <= wr_data[7];
        wram_wp_q <= wr_data[6];
      end
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic bank_en;
    always_comb bank_en = data_en && (ctrl_q.idx == IDX_W'(g));
    always_ff @(negedge bus_clk or negedge rst_sync_n) begin
      if (!rst_sync_n)  bank_q[g] <= '0;
      else if (bank_en) bank_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/mmc_prg_xlate.sv
module mmc_prg_xlate
  import mmc_map_pkg::*;
#(
  parameter int PRG_W = 6
) (
  input  logic             prg_swap,
  input  logic [1:0]       cpu_win,
  input  logic [REG_W-1:0] bank6,
  input  logic [REG_W-1:0] bank7,
  output logic [PRG_W-1:0] prg_bank
);
  localparam logic [PRG_W-1:0] LAST_BANK   = '1;
  localparam logic [PRG_W-1:0] SECOND_LAST = LAST_BANK - PRG_W'(1);

  always_comb begin
    unique case (cpu_win)
      2'd0:    prg_bank = prg_swap ? SECOND_LAST : bank6[PRG_W-1:0];
      2'd1:    prg_bank = bank7[PRG_W-1:0];
      2'd2:    prg_bank = prg_swap ? bank6[PRG_W-1:0] : SECOND_LAST;
      default: prg_bank = LAST_BANK;
    endcase
  end
endmodule

// File: rtl/mmc_chr_xlate.sv
module mmc_chr_xlate
  import mmc_map_pkg::*;
#(
  parameter int CHR_W = 8
) (
  input  logic             chr_inv,
  input  logic [2:0]       ppu_a12_10,
  input  bank_arr_t        bank_q,
  output logic [CHR_W-1:0] chr_bank
);
  logic             half_sel;
  logic [REG_W-1:0] pair_val;
  logic [REG_W-1:0] quad_val;

  always_comb begin
    half_sel = ppu_a12_10[2] ^ chr_inv;
    pair_val = ppu_a12_10[1] ? bank_q[1] : bank_q[0];
    quad_val = bank_q[2 + int'(ppu_a12_10[1:0])];
    if (!half_sel) chr_bank = {pair_val[CHR_W-1:1], ppu_a12_10[0]};
    else           chr_bank = quad_val[CHR_W-1:0];
  end
endmodule

// File: rtl/mmc_bank_mapper.sv
module mmc_bank_mapper
  import mmc_map_pkg::*;
#(
  parameter int PRG_W = 6,
  parameter int CHR_W = 8
) (
  input  logic             bus_clk,
  input  logic             rst_n,
  input  logic [2:0]       cpu_a15_13,
  input  logic             cpu_a0,
  input  logic             cpu_rw,
  input  logic             prg_ce_n,
  input  logic [7:0]       cpu_din,
  input  logic [2:0]       ppu_a12_10,
  output logic [PRG_W-1:0] prg_bank,
  output logic [CHR_W-1:0] chr_bank,
  output logic             ntab_a10,
  output logic             wram_ce,
  output logic             wram_we
);
  logic      rst_meta, rst_sync_n;
  logic      wr_strobe;
  logic [2:0] wr_key;
  ctrl_t     ctrl_q;
  bank_arr_t bank_q;
  logic      mirror_q, wram_en_q, wram_wp_q;
  logic      chr_inv, prg_swap;

  always_ff @(negedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    wr_strobe = !cpu_rw && !prg_ce_n && cpu_a15_13[2];
    wr_key    = {cpu_a15_13[1:0], cpu_a0};
    chr_inv   = ctrl_q.chr_inv;
    prg_swap  = ctrl_q.prg_swap;
  end

  mmc_reg_file u_regs (
    .bus_clk    (bus_clk),
    .rst_sync_n (rst_sync_n),
    .wr_strobe  (wr_strobe),
    .wr_key     (wr_key),
    .wr_data    (cpu_din),
    .ctrl_q     (ctrl_q),
    .bank_q     (bank_q),
    .mirror_q   (mirror_q),
    .wram_en_q  (wram_en_q),
    .wram_wp_q  (wram_wp_q)
  );

  mmc_prg_xlate #(.PRG_W(PRG_W)) u_prg (
    .prg_swap (prg_swap),
    .cpu_win  (cpu_a15_13[1:0]),
    .bank6    (bank_q[6]),
    .bank7    (bank_q[7]),
    .prg_bank (prg_bank)
  );

  mmc_chr_xlate #(.CHR_W(CHR_W)) u_chr (
    .chr_inv    (chr_inv),
    .ppu_a12_10 (ppu_a12_10),
    .bank_q     (bank_q),
    .chr_bank   (chr_bank)
  );

  always_comb begin
    ntab_a10 = mirror_q ? ppu_a12_10[1] : ppu_a12_10[0];
    wram_ce  = wram_en_q && (cpu_a15_13 == 3'b011);
    wram_we  = wram_ce && !wram_wp_q && !cpu_rw;
  end
endmodule

// File: rtl/mmc_bank_mapper_chk.sv
module mmc_bank_mapper_chk
  import mmc_map_pkg::*;
#(
  parameter int PRG_W = 6,
  parameter int CHR_W = 8
) (
  input logic             bus_clk,
  input logic             rst_n,
  input logic             wr_strobe,
  input bank_arr_t        bank_q,
  input logic             chr_inv,
  input logic             prg_swap,
  input logic             wram_en_q,
  input logic [2:0]       cpu_a15_13,
  input logic             cpu_rw,
  input logic [2:0]       ppu_a12_10,
  input logic [PRG_W-1:0] prg_bank,
  input logic [CHR_W-1:0] chr_bank,
  input logic             wram_ce,
  input logic             wram_we
);
  a_r1_no_write_no_change: assert property (@(negedge bus_clk) disable iff (!rst_n)
    !wr_strobe |=> $stable(bank_q));

  a_r5_last_window_fixed: assert property (@(negedge bus_clk) disable iff (!rst_n)
    (cpu_a15_13[1:0] == 2'b11) |-> (prg_bank == {PRG_W{1'b1}}));

  a_r6_swap_second_last: assert property (@(negedge bus_clk) disable iff (!rst_n)
    (prg_swap && cpu_a15_13[1:0] == 2'b00) |-> (prg_bank == {{(PRG_W-1){1'b1}}, 1'b0}));

  a_r3_a10_passthrough: assert property (@(negedge bus_clk) disable iff (!rst_n)
    !(ppu_a12_10[2] ^ chr_inv) |-> (chr_bank[0] == ppu_a12_10[0]));

  a_r9_ce_needs_enable: assert property (@(negedge bus_clk) disable iff (!rst_n)
    !wram_en_q |-> !wram_ce);

  a_r9_we_implies_ce: assert property (@(negedge bus_clk) disable iff (!rst_n)
    wram_we |-> (wram_ce && !cpu_rw));
endmodule

bind mmc_bank_mapper mmc_bank_mapper_chk #(.PRG_W(PRG_W), .CHR_W(CHR_W)) u_chk (
  .bus_clk    (bus_clk),
  .rst_n      (rst_sync_n),
  .wr_strobe  (wr_strobe),
  .bank_q     (bank_q),
  .chr_inv    (chr_inv),
  .prg_swap   (prg_swap),
  .wram_en_q  (wram_en_q),
  .cpu_a15_13 (cpu_a15_13),
  .cpu_rw     (cpu_rw),
  .ppu_a12_10 (ppu_a12_10),
  .prg_bank   (prg_bank),
  .chr_bank   (chr_bank),
  .wram_ce    (wram_ce),
  .wram_we    (wram_we)
);

// File: tb/sim_mmc_bank_mapper.sv
module sim_mmc_bank_mapper;
  localparam int PRG_W = 6;
  localparam int CHR_W = 8;

  logic             bus_clk = 1'b0;
  logic             rst_n;
  logic [2:0]       cpu_a15_13;
  logic             cpu_a0, cpu_rw, prg_ce_n;
  logic [7:0]       cpu_din;
  logic [2:0]       ppu_a12_10;
  logic [PRG_W-1:0] prg_bank;
  logic [CHR_W-1:0] chr_bank;
  logic             ntab_a10, wram_ce, wram_we;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 0;

  // bench model of the stored state
  bit       m_inv, m_swap, m_mir, m_wen, m_wp;
  bit [2:0] m_idx;
  bit [7:0] m_bank [8];

  always #2.5 bus_clk = ~bus_clk;

  mmc_bank_mapper #(.PRG_W(PRG_W), .CHR_W(CHR_W)) u0 (
    .bus_clk(bus_clk), .rst_n(rst_n), .cpu_a15_13(cpu_a15_13), .cpu_a0(cpu_a0),
    .cpu_rw(cpu_rw), .prg_ce_n(prg_ce_n), .cpu_din(cpu_din), .ppu_a12_10(ppu_a12_10),
    .prg_bank(prg_bank), .chr_bank(chr_bank), .ntab_a10(ntab_a10),
    .wram_ce(wram_ce), .wram_we(wram_we)
  );

  function automatic bit [PRG_W-1:0] exp_prg(bit [2:0] a);
    bit [PRG_W-1:0] last = '1;
    case (a[1:0])
      2'd0: return m_swap ? last - 1 : m_bank[6][PRG_W-1:0];
      2'd1: return m_bank[7][PRG_W-1:0];
      2'd2: return m_swap ? m_bank[6][PRG_W-1:0] : last - 1;
      default: return last;
    endcase
  endfunction

  function automatic bit [CHR_W-1:0] exp_chr(bit [2:0] p);
    bit a12 = p[2] ^ m_inv;
    bit [7:0] v;
    if (!a12) begin
      v = m_bank[p[1] ? 1 : 0];
      v[0] = p[0];
    end else begin
      v = m_bank[2 + p[1:0]];
    end
    return v[CHR_W-1:0];
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic probe(string tag, bit [2:0] a, bit [2:0] p, bit rw);
    cpu_a15_13 = a; ppu_a12_10 = p; cpu_rw = rw; prg_ce_n = 1'b1;
    #0.5;
    cmp(tag, "prg_bank", int'(prg_bank), int'(exp_prg(a)));
    cmp(tag, "chr_bank", int'(chr_bank), int'(exp_chr(p)));
    cmp(tag, "ntab_a10", int'(ntab_a10), int'(m_mir ? p[1] : p[0]));
    cmp(tag, "wram_ce", int'(wram_ce), int'(m_wen && a == 3'b011));
    cmp(tag, "wram_we", int'(wram_we), int'(m_wen && a == 3'b011 && !m_wp && !rw));
  endtask

  task automatic probe_all(string tag);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        probe(tag, 3'(i), 3'(j), 1'(j));
  endtask

  // bus cycle; the model follows R1/R2/R8/R9/R11 only when the cycle is a valid write
  task automatic bus_write(bit [2:0] a, bit a0, bit [7:0] d, bit rw = 1'b0, bit ce_n = 1'b0);
    @(posedge bus_clk); #1;
    cpu_a15_13 = a; cpu_a0 = a0; cpu_din = d; cpu_rw = rw; prg_ce_n = ce_n;
    @(negedge bus_clk); #1;
    cpu_rw = 1'b1; prg_ce_n = 1'b1;
    if (!rw && !ce_n && a[2]) begin
      case ({a[1:0], a0})
        3'b000: begin m_inv = d[7]; m_swap = d[6]; m_idx = d[2:0]; end
        3'b001: m_bank[m_idx] = d;
        3'b010: m_mir = d[0];
        3'b011: begin m_wen = d[7]; m_wp = d[6]; end
        default: ;
      endcase
    end
  endtask

  task automatic load_bank(int idx, bit [7:0] v, bit inv = 0, bit swp = 0);
    bus_write(3'b100, 1'b0, {inv, swp, 3'b000, 3'(idx)});
    bus_write(3'b100, 1'b1, v);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd4242);
    rst_n = 1'b0; cpu_a15_13 = 3'b000; cpu_a0 = 1'b0; cpu_rw = 1'b1;
    prg_ce_n = 1'b1; cpu_din = 8'h00; ppu_a12_10 = 3'b000;
    m_inv = 0; m_swap = 0; m_mir = 0; m_wen = 0; m_wp = 0; m_idx = 0;
    for (int k = 0; k < 8; k++) m_bank[k] = 8'h00;
    repeat (4) @(posedge bus_clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge bus_clk);

    // R10: reset state
    probe_all("R10");

    // R3: odd values in the 2 KB registers, A10 replaces bit 0
    load_bank(0, 8'h35);
    load_bank(1, 8'hC8);
    probe("R3", 3'b100, 3'b000, 1); probe("R3", 3'b100, 3'b001, 1);
    probe("R3", 3'b100, 3'b010, 1); probe("R3", 3'b100, 3'b011, 1);
    // R4: distinct 1 KB registers
    load_bank(2, 8'h11); load_bank(3, 8'h22); load_bank(4, 8'h44); load_bank(5, 8'h88);
    for (int j = 4; j < 8; j++) probe("R4", 3'b100, 3'(j), 1);
    // R7: invert flag moves the whole lookup
    bus_write(3'b100, 1'b0, 8'h80);
    probe_all("R7");
    // R5/R6: program windows with both swap settings
    load_bank(6, 8'h07); load_bank(7, 8'h1A);
    probe_all("R5");
    bus_write(3'b100, 1'b0, 8'h40);
    probe_all("R6");
    // R2: index selects the target, data port loads it
    bus_write(3'b100, 1'b0, 8'h47);
    bus_write(3'b100, 1'b1, 8'h2B);
    probe_all("R2");
    // R8: mirroring
    bus_write(3'b101, 1'b0, 8'h01); probe_all("R8");
    bus_write(3'b101, 1'b0, 8'hFE); probe_all("R8");
    // R9: all four work-RAM flag combinations
    for (int f = 0; f < 4; f++) begin
      bus_write(3'b101, 1'b1, {2'(f), 6'h00});
      probe_all("R9");
    end
    // R1: invalid bus cycles ignored
    bus_write(3'b100, 1'b1, 8'hFF, 1'b1, 1'b0);
    bus_write(3'b100, 1'b1, 8'hFF, 1'b0, 1'b1);
    bus_write(3'b000, 1'b1, 8'hFF, 1'b0, 1'b0);
    bus_write(3'b000, 1'b0, 8'hC7, 1'b0, 1'b0);
    probe_all("R1");
    // R11: interrupt-range keys store nothing
    for (int k = 4; k < 8; k++) bus_write(3'b110 | 3'(k[1]), 1'(k[0]), 8'hA5);
    bus_write(3'b111, 1'b1, 8'hFF);
    probe_all("R11");

    // random mix
    for (int it = 0; it < 400; it++) begin
      bit [2:0] a  = 3'($urandom_range(0, 7));
      bit       a0 = 1'($urandom);
      bit [7:0] d  = 8'($urandom);
      bit       rw = ($urandom_range(0, 9) == 0);
      bit       cn = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 3) != 0) a[2] = 1'b1;
      bus_write(a, a0, d, rw, cn);
      for (int q = 0; q < 4; q++)
        probe("R1", 3'($urandom), 3'($urandom), 1'($urandom));
    end
    probe_all("R2");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule